// File: doc/BRIEF.md
# Single-Word Stream Transmitter

This block puts one data word at a time onto a streaming master port with a valid/ready handshake. The user places a word on `word_in` and pulses `start` for one cycle. The block copies the word into its output register and raises `m_tvalid` and `m_tlast` together. Every transfer is a complete one-beat packet. The outputs stay unchanged until the downstream sink raises `m_tready`.

A handshake happens on any rising clock edge where `m_tvalid` and `m_tready` are both high. In the cycle after that edge, the block raises `done` for one cycle, so the user knows the word was taken. A `start` that arrives while a word is still waiting is dropped. A `start` that lands on the handshake edge itself loads the next word straight away, so back-to-back words carry no idle cycle between them.

Top module: `stream_word_tx`

## Requirements
- R1: While `rst_n` is low, `m_tvalid`, `m_tlast` and `done` are low and `m_tdata` is zero. Reset acts without waiting for a clock edge.
- R2: With no word pending, `start` high at a rising edge copies `word_in` into `m_tdata` and raises `m_tvalid` in the following cycle.
- R3: `m_tlast` equals `m_tvalid` in every cycle, so every transfer is a single-beat packet.
- R4: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tvalid` and `m_tlast` keep their values, for any number of cycles.
- R5: A handshake occurs at a rising edge where `m_tvalid` and `m_tready` are both high. If `start` is low at that edge, `m_tvalid` and `m_tlast` are low in the next cycle.
- R6: `done` is high for exactly the one cycle that follows each handshake edge, and is low at all other times.
- R7: `start` at an edge where `m_tvalid` is high and `m_tready` is low is ignored. `m_tdata` keeps the pending word, and no extra transfer follows.
- R8: `start` at a handshake edge loads the new `word_in`. `m_tvalid` stays high into the next cycle, and `done` is raised for the completed word.
- R9: If `m_tready` is already high when a word is loaded, the handshake completes at the very next edge, so `m_tvalid` is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_in | input | WIDTH | Word to send, valid when `start` is high |
| start | input | 1 | One-cycle request to send `word_in` |
| m_tdata | output | WIDTH | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tlast | output | 1 | End of packet, high together with valid |
| m_tready | input | 1 | Stream ready from the sink |
| done | output | 1 | One-cycle pulse after a word is accepted |

## Verification
The hardest case to reach is a new `start` that lands on the same edge as the handshake. The bench sets this up on purpose: it holds a word pending with `m_tready` low, then at one falling edge raises `m_tready` and `start` together with a different word. This checks that the new word replaces the old one, that `m_tvalid` never drops, and that `done` is raised for two cycles in a row, once for each word. The check that a `start` during a stall is ignored is made at the ports: the bench reads `m_tdata`, then completes the handshake and confirms that no second transfer appears.

// File: rtl/stream_word_tx.sv
module stream_word_tx #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] word_in,
  input  logic             start,
  output logic [WIDTH-1:0] m_tdata,
  output logic             m_tvalid,
  output logic             m_tlast,
  input  logic             m_tready,
  output logic             done
);

  logic accepted;
  logic stalled;
  logic load;

  assign accepted = m_tvalid & m_tready;
  assign stalled  = m_tvalid & ~m_tready;
  assign load     = start & ~stalled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tdata  <= '0;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= accepted;
      if (load) begin
        m_tdata  <= word_in;
        m_tvalid <= 1'b1;
        m_tlast  <= 1'b1;
      end else if (accepted) begin
        m_tvalid <= 1'b0;
        m_tlast  <= 1'b0;
      end
    end
  end

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid == m_tlast); // R3

  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_tvalid && start) |=> (m_tvalid && m_tdata == $past(word_in))); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && m_tlast && $stable(m_tdata))); // R4

  AST_DROP_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && !start) |=> !m_tvalid); // R5

  AST_DONE_FOLLOWS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready) |=> done); // R6

  AST_DONE_ONLY_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> !done); // R6

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && start) |=> (m_tdata == $past(m_tdata))); // R7

  AST_CHAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && start) |=> (m_tvalid && done && m_tdata == $past(word_in))); // R8

endmodule

// File: tb/stream_word_tx_bench.sv
`timescale 1ns / 1ps
module stream_word_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NVEC = 6;
  localparam logic [39:0] VEC [NVEC] = '{
    {32'hAAAA_BBBB, 8'd0},
    {32'hCCCC_DDDD, 8'd1},
    {32'h0000_0000, 8'd3},
    {32'hFFFF_FFFF, 8'd7},
    {32'h1234_5678, 8'd2},
    {32'h8000_0001, 8'd12}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] word_in = '0;
  logic start = 1'b0;
  logic m_tready = 1'b0;
  logic [W-1:0] m_tdata;
  logic m_tvalid, m_tlast, done;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_word_tx #(.WIDTH(W)) u_stream_word_tx (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .start(start),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast),
    .m_tready(m_tready), .done(done)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    check("R1 tvalid in reset", W'(m_tvalid), 0);
    check("R1 tdata in reset", m_tdata, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done idle", W'(done), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [W-1:0] w;
      int d;
      w = VEC[i][39:8];
      d = int'(VEC[i][7:0]);
      word_in = w; start = 1'b1; m_tready = 1'b0;
      @(negedge clk);
      start = 1'b0; word_in = ~w;
      check("R2 tvalid", W'(m_tvalid), 1);
      check("R2 tdata", m_tdata, w);
      check("R3 tlast", W'(m_tlast), 1);
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        check("R4 hold tdata", m_tdata, w);
        check("R4 hold tvalid/tlast", W'({m_tvalid, m_tlast}), 3);
        check("R6 no done while stalled", W'(done), 0);
      end
      m_tready = 1'b1;
      @(negedge clk);
      m_tready = 1'b0;
      check("R6 done after handshake", W'(done), 1);
      check("R5 tvalid drops", W'(m_tvalid), 0);
      check("R3 tlast drops", W'(m_tlast), 0);
      @(negedge clk);
      check("R6 done one cycle", W'(done), 0);
    end

    word_in = 32'h1111_1111; start = 1'b1;
    @(negedge clk);
    word_in = 32'h2222_2222;
    @(negedge clk);
    start = 1'b0;
    check("R7 busy start ignored", m_tdata, 32'h1111_1111);
    m_tready = 1'b1;
    @(negedge clk);
    m_tready = 1'b0;
    check("R7 done for first word", W'(done), 1);
    check("R7 no extra transfer", W'(m_tvalid), 0);
    @(negedge clk);
    check("R7 stays idle", W'(m_tvalid), 0);

    word_in = 32'h3333_3333; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    word_in = 32'h4444_4444; start = 1'b1; m_tready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 new word loaded", m_tdata, 32'h4444_4444);
    check("R8 tvalid stays high", W'(m_tvalid), 1);
    check("R8 done for old word", W'(done), 1);
    @(negedge clk);
    m_tready = 1'b0;
    check("R8 second done", W'(done), 1);
    check("R8 tvalid drops", W'(m_tvalid), 0);
    @(negedge clk);
    check("R6 done low again", W'(done), 0);

    m_tready = 1'b1; word_in = 32'h5555_AAAA; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 loaded with ready high", m_tdata, 32'h5555_AAAA);
    check("R9 done not yet", W'(done), 0);
    @(negedge clk);
    check("R9 one-cycle valid", W'(m_tvalid), 0);
    check("R9 done", W'(done), 1);
    m_tready = 1'b0;

    word_in = 32'h7777_7777; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    check("R1 async clears tvalid", W'(m_tvalid), 0);
    check("R1 async clears tlast", W'(m_tlast), 0);
    check("R1 async clears tdata", m_tdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", W'({m_tvalid, done}), 0);

    finish_run();
  end
endmodule